// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier

This block is the multiply stage of a small 8-bit processor. It takes two register operands, multiplies them under one of six operand interpretations, and returns a 16-bit product together with a carry flag and a zero flag. The six interpretations are unsigned by unsigned, signed by signed, and signed by unsigned, each in an integer form and a fractional form. The fractional form doubles the product so that two fixed-point fractions give a fixed-point result with the binary point in the same place.

A 3-bit mode code selects the interpretation. Bit 2 of the code selects the fractional form. Bits 1:0 select signedness: `00` unsigned, `01` both signed, `10` operand A signed and operand B unsigned, `11` reserved and treated as unsigned. The caller raises `start` for one cycle with the operands and the mode. One clock later the result and flags are valid, and `done` pulses. The outputs then hold until the next `start`.

All interpretations share one datapath. Each operand is widened by one bit, with either a copy of its sign bit or a zero. One signed multiplier then serves every mode. A post stage applies the fractional doubling and forms the flags.

Top module: `mul8_unit`

## Requirements
- R1: While `rst` is high, and after it falls until the first `start`, `product` is 0 and `carry`, `zero` and `done` are 0.
- R2: With mode `000`, `product` is the unsigned product of `opa` and `opb`.
- R3: With mode `001`, `product` is the low 16 bits of the product of `opa` and `opb`, both read as two's complement.
- R4: With mode `010`, `product` is the low 16 bits of the product of `opa` read as two's complement and `opb` read as unsigned.
- R5: With mode bit 2 set, the full product of the selected interpretation is shifted left by one bit and truncated to 16 bits, so `product[0]` is 0.
- R6: `carry` equals bit 15 of the product before any fractional shift, in every mode.
- R7: `zero` is 1 exactly when the final 16-bit `product` equals 0.
- R8: `product`, `carry`, `zero` and `done` update on the clock edge that samples `start` high. `done` is high for exactly the cycles that follow a cycle with `start` high.
- R9: In a cycle with `start` low, changes on `opa`, `opb` and `mode` have no effect, and `product`, `carry` and `zero` keep their values.
- R10: Modes `011` and `111` behave as modes `000` and `100`: both operands are read as unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply with the current operands and mode |
| mode | input | 3 | Bit 2 selects the fractional form; bits 1:0 select signedness |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| product | output | 2W | Result of the last multiply |
| carry | output | 1 | Bit 15 of the unshifted product |
| zero | output | 1 | Result equals zero |
| done | output | 1 | Result valid; single-cycle pulse after each start |

## Verification
The bench builds the block with the default operand width of 8. At that width every mode can be run against every pairing of the edge operands 0x00, 0x01, 0x7F, 0x80 and 0xFF. These pairings reach the sign boundaries where signed and mixed products differ from unsigned ones. They also include the 0x80 by 0x80 case, whose fractional result wraps to 0x8000 with carry clear. Random operands and idle cycles with changing inputs fill in the general products and the hold behaviour.

// File: rtl/mul8_pkg.sv
package mul8_pkg;

    localparam int OPW_DEF = 8;

    // Signedness selector, taken from mode bits 1:0
    typedef enum logic [1:0] {
        SGN_UU  = 2'b00,
        SGN_SS  = 2'b01,
        SGN_SU  = 2'b10,
        SGN_RSV = 2'b11
    } sign_sel_e;

    typedef struct packed {
        logic a_signed;
        logic b_signed;
        logic frac;
    } mode_ctl_t;

    function automatic mode_ctl_t decode_mode(input logic [2:0] m);
        mode_ctl_t c;
        sign_sel_e s;
        s = sign_sel_e'(m[1:0]);
        c.frac = m[2];
        case (s)
            SGN_SS:  begin c.a_signed = 1'b1; c.b_signed = 1'b1; end
            SGN_SU:  begin c.a_signed = 1'b1; c.b_signed = 1'b0; end
            default: begin c.a_signed = 1'b0; c.b_signed = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mul8_opext.sv
module mul8_opext #(
    parameter int W = 8
) (
    input  logic [W-1:0]      opnd,
    input  logic              is_signed,
    output logic signed [W:0] ext
);
    // One extra bit: sign copy for signed operands, zero otherwise
    assign ext = $signed({is_signed & opnd[W-1], opnd});
endmodule

// File: rtl/mul8_core.sv
module mul8_core #(
    parameter int W = 8
) (
    input  logic signed [W:0] a_ext,
    input  logic signed [W:0] b_ext,
    output logic [2*W-1:0]    raw
);
    localparam int FW = 2*W + 2;

    logic signed [FW-1:0] a_full;
    logic signed [FW-1:0] b_full;
    logic signed [FW-1:0] full;

    assign a_full = $signed({{(W+1){a_ext[W]}}, a_ext});
    assign b_full = $signed({{(W+1){b_ext[W]}}, b_ext});
    assign full   = a_full * b_full;
    assign raw    = full[2*W-1:0];
endmodule

// File: rtl/mul8_post.sv
module mul8_post #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] raw,
    input  logic           frac,
    output logic [2*W-1:0] result,
    output logic           carry,
    output logic           zero
);
    localparam int PW = 2*W;

    logic [PW-1:0] doubled;

    assign doubled = {raw[PW-2:0], 1'b0};

    always_comb begin
        result = frac ? doubled : raw;
        carry  = raw[PW-1];
        zero   = (result == '0);
    end
endmodule

// File: rtl/mul8_unit.sv
module mul8_unit
    import mul8_pkg::*;
#(
    parameter int W = OPW_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [2*W-1:0] product,
    output logic           carry,
    output logic           zero,
    output logic           done
);
    localparam int PW = 2*W;

    mode_ctl_t         ctl;
    logic signed [W:0] a_ext;
    logic signed [W:0] b_ext;
    logic [PW-1:0]     raw;
    logic [PW-1:0]     res_c;
    logic              carry_c;
    logic              zero_c;

    assign ctl = decode_mode(mode);

    mul8_opext #(.W(W)) u_ext_a (.opnd(opa), .is_signed(ctl.a_signed), .ext(a_ext));
    mul8_opext #(.W(W)) u_ext_b (.opnd(opb), .is_signed(ctl.b_signed), .ext(b_ext));

    mul8_core #(.W(W)) u_core (.a_ext(a_ext), .b_ext(b_ext), .raw(raw));

    mul8_post #(.W(W)) u_post (
        .raw(raw), .frac(ctl.frac),
        .result(res_c), .carry(carry_c), .zero(zero_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            product <= '0;
            carry   <= 1'b0;
            zero    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                product <= res_c;
                carry   <= carry_c;
                zero    <= zero_c;
            end
        end
    end
endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [2:0]     mode,
    input logic [W-1:0]   opa,
    input logic [W-1:0]   opb,
    input logic [2*W-1:0] product,
    input logic           carry,
    input logic           zero,
    input logic           done
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (product == '0 && !carry && !zero && !done));

    // R8
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(product) && $stable(carry) && $stable(zero)));

    // R5
    frac_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode[2]) |=> (product[0] == 1'b0));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (zero == (product == '0)));
endmodule

bind mul8_unit mul8_unit_chk #(.W(W)) u_chk (.*);

// File: tb/mul8_unit_tb.sv
module mul8_unit_tb;
    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [2:0]    mode;
    logic [W-1:0]  opa, opb;
    logic [15:0]   product;
    logic          carry, zero, done;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] e_prod;
    logic        e_carry, e_zero, e_done;
    string       e_tag;

    always #10 clk = ~clk;

    mul8_unit #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .opa(opa), .opb(opb), .product(product),
        .carry(carry), .zero(zero), .done(done)
    );

    // Behavioural reference, updated at every rising edge
    always @(posedge clk) begin
        if (rst) begin
            e_prod <= '0; e_carry <= 1'b0; e_zero <= 1'b0; e_done <= 1'b0;
            e_tag  <= "R1";
        end else if (start) begin
            int av, bv, p;
            logic [31:0] pu;
            logic [15:0] r16, fin;
            logic sa, sb;
            sa = (mode[1:0] == 2'b01) || (mode[1:0] == 2'b10);
            sb = (mode[1:0] == 2'b01);
            av = int'(opa); bv = int'(opb);
            if (sa && opa[7]) av = av - 256;
            if (sb && opb[7]) bv = bv - 256;
            p   = av * bv;
            pu  = p;
            r16 = pu[15:0];
            fin = mode[2] ? {r16[14:0], 1'b0} : r16;
            e_prod  <= fin;
            e_carry <= r16[15];
            e_zero  <= (fin == 16'h0);
            e_done  <= 1'b1;
            case (mode)
                3'b000: e_tag <= "R2";
                3'b001: e_tag <= "R3";
                3'b010: e_tag <= "R4";
                3'b100: e_tag <= "R2 R5";
                3'b101: e_tag <= "R3 R5";
                3'b110: e_tag <= "R4 R5";
                default: e_tag <= "R10";
            endcase
        end else begin
            e_done <= 1'b0;
            e_tag  <= "R9";
        end
    end

    task automatic compare();
        n_cmp++;
        if (product !== e_prod) begin
            n_bad++;
            $display("FAIL %s product: actual %h expected %h", e_tag, product, e_prod);
        end
        n_cmp++;
        if (carry !== e_carry) begin
            n_bad++;
            $display("FAIL R6 (%s) carry: actual %b expected %b", e_tag, carry, e_carry);
        end
        n_cmp++;
        if (zero !== e_zero) begin
            n_bad++;
            $display("FAIL R7 (%s) zero: actual %b expected %b", e_tag, zero, e_zero);
        end
        n_cmp++;
        if (done !== e_done) begin
            n_bad++;
            $display("FAIL R8 (%s) done: actual %b expected %b", e_tag, done, e_done);
        end
    endtask

    // Compare at the falling edge, then drive the next cycle's inputs
    task automatic step(input logic s, input logic [2:0] m,
                        input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        compare();
        start = s; mode = m; opa = a; opb = b;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] corners [5];
        corners[0] = 8'h00; corners[1] = 8'h01; corners[2] = 8'h7F;
        corners[3] = 8'h80; corners[4] = 8'hFF;
        rst = 1'b1; start = 1'b0; mode = '0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        compare(); // R1 during reset
        rst = 1'b0;
        // R1 after reset, inputs moving but no start
        step(1'b0, 3'b001, 8'hFF, 8'h80);
        step(1'b0, 3'b000, 8'h12, 8'h34);
        // R2..R5, R10 over all corner pairs, separated by idle cycles
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    step(1'b1, 3'(m), corners[i], corners[j]);
                    // R9: idle with changed inputs
                    step(1'b0, 3'(7 - m), corners[j], corners[i]);
                end
            end
        end
        // Back-to-back starts (R8) and random operands
        for (int k = 0; k < 400; k++) begin
            step(1'b1, 3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom));
            if (k % 7 == 0)
                step(1'b0, 3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom));
        end
        step(1'b0, 3'b000, 8'h00, 8'h00);
        step(1'b0, 3'b101, 8'hAA, 8'h55);
        // Reset again mid-stream (R1)
        @(negedge clk);
        rst = 1'b1;
        step(1'b1, 3'b000, 8'hFF, 8'hFF);
        rst = 1'b0; start = 1'b0;
        step(1'b0, 3'b000, 8'h00, 8'h00);
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule